// File: doc/BRIEF.md
# Indexed Peripheral Clock Configuration Register

This block gathers the clock settings of up to 64 peripherals behind one 32-bit control word. The settings are reached indirectly. A write without the command flag only points the block at a peripheral. A read then shows the settings of that peripheral. A write with the command flag stores a new enable bit and divider code for the peripheral named in the same word, and also points the block at it.

Each peripheral keeps an enable bit and a 2-bit divider code. The code selects a divide ratio of 1, 2, 4 or 8. From these the block produces one clock-enable pulse stream per peripheral, with one pulse of one parent cycle for every 2^code parent cycles. The stream is silent while the enable bit is clear. To turn a peripheral off, software reads its word and writes it back with the enable bit cleared and the command flag set. The divider code is kept for the next time the peripheral is turned on.

Top module: `pclk_cfg_top`

## Requirements
- R1: After reset every peripheral has enable 0 and divider code 0, the selector holds ID 0, the read word is all zeros, and no enable pulse is asserted.
- R2: A write with bit 12 (command) at 0 loads bits 5:0 into the selector. It changes no stored enable bit or divider code.
- R3: The read word carries the selected ID in bits 5:0, that peripheral's divider code in bits 17:16 and its enable bit in bit 28. Every other bit reads 0, including bit 12. Bits outside these fields in a write are ignored.
- R4: A write with bit 12 at 1 stores bits 17:16 as the divider code and bit 28 as the enable bit of the peripheral whose ID is in bits 5:0. It also selects that peripheral. The change is visible on the next read.
- R5: Writing a peripheral's read word back with bit 28 cleared and bit 12 set turns its pulses off and leaves its divider code unchanged.
- R6: A command write changes only the addressed peripheral. The other 63 keep their settings and their pulse streams.
- R7: Over any 64 consecutive parent cycles after a setting has taken effect, an enabled peripheral with code d gives exactly 64/2^d pulses, and a disabled peripheral gives none. An enable change takes effect in the cycle after the write.
- R8: Each peripheral has a 3-bit counter. The counter is 0 in the first cycle after reset and counts every parent cycle. A pulse is asserted exactly in the cycles where the low d bits of the counter are zero and the enable bit is set.
- R9: A new divider code takes effect only in the cycle after the counter reads 7. Until then the previous code still governs the pulse pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Parent clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Write data: ID, command, divider code, enable |
| rd_data_o | output | 32 | Read word for the selected peripheral |
| clk_en_o | output | 64 | Per-peripheral clock-enable pulses |

## Verification
The hardest case to reach from the ports is a divider change that lands between counter wraps. The old code must then keep driving the pulse pattern until the counter passes 7. The bench waits for a known counter phase, which it tracks on its own from the release of reset. It then issues the write at that phase and samples the pulse at phases where the old and new codes disagree. Random select and command writes, with random bits in the unused positions, are checked every cycle against a model of all 64 pulse streams.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned DIV_W   = 2;
  localparam int unsigned CNT_W   = 3;
  localparam int unsigned ID_LSB  = 0;
  localparam int unsigned CMD_BIT = 12;
  localparam int unsigned DIV_LSB = 16;
  localparam int unsigned EN_BIT  = 28;

  // low-bit mask selected by a divider code
  function automatic logic [CNT_W-1:0] div_mask(input logic [DIV_W-1:0] code);
    logic [CNT_W-1:0] ones;
    ones = '1;
    return ~(ones << code);
  endfunction
endpackage

// File: rtl/pclk_cfg_bank.sv
module pclk_cfg_bank
  import pclk_pkg::*;
#(
  parameter int unsigned N_PERIPH = 64,
  localparam int unsigned ID_W = $clog2(N_PERIPH)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [DATA_W-1:0]              wr_data_i,
  output logic [DATA_W-1:0]              rd_data_o,
  output logic [N_PERIPH-1:0][DIV_W-1:0] div_o,
  output logic [N_PERIPH-1:0]            en_o
);
  logic [ID_W-1:0]              sel_q;
  logic [N_PERIPH-1:0][DIV_W-1:0] div_q;
  logic [N_PERIPH-1:0]            en_q;

  logic [ID_W-1:0]  wr_id;
  logic             wr_cmd;
  logic [DIV_W-1:0] wr_div;
  logic             wr_enb;

  assign wr_id  = wr_data_i[ID_LSB +: ID_W];
  assign wr_cmd = wr_data_i[CMD_BIT];
  assign wr_div = wr_data_i[DIV_LSB +: DIV_W];
  assign wr_enb = wr_data_i[EN_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      div_q <= '0;
      en_q  <= '0;
    end else if (wr_en_i) begin
      sel_q <= wr_id;
      if (wr_cmd) begin
        div_q[wr_id] <= wr_div;
        en_q[wr_id]  <= wr_enb;
      end
    end
  end

  always_comb begin
    rd_data_o                     = '0;
    rd_data_o[ID_LSB +: ID_W]     = sel_q;
    rd_data_o[DIV_LSB +: DIV_W]   = div_q[sel_q];
    rd_data_o[EN_BIT]             = en_q[sel_q];
  end

  assign div_o = div_q;
  assign en_o  = en_q;

  // R2: a selector-only write keeps all stored settings
  a_r2_select_keeps_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_cmd) |=> ($stable(div_q) && $stable(en_q)));

  // R4: a command write lands in the addressed entry
  a_r4_cmd_stores_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_cmd) |=> (en_q[$past(wr_id)] == $past(wr_enb)));

  a_r4_cmd_stores_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_cmd) |=> (div_q[$past(wr_id)] == $past(wr_div)));

  // R3: command flag never reads back
  a_r3_cmd_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rd_data_o[CMD_BIT] == 1'b0));
endmodule

// File: rtl/pclk_pulse_gen.sv
module pclk_pulse_gen
  import pclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             pulse_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [DIV_W-1:0] act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (&cnt_q) act_q <= div_i;  // adopt new code only at wrap
    end
  end

  assign pulse_o = en_i && ((cnt_q & div_mask(act_q)) == '0);

  // R9: active code holds between wraps
  a_r9_code_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&cnt_q) |=> $stable(act_q));

  // R8: divide-by-8 never pulses twice in a row
  a_r8_no_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && act_q == 2'd3) |=> !pulse_o);

  // R8: counter advances every cycle
  a_r8_counter_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/pclk_cfg_top.sv
module pclk_cfg_top
  import pclk_pkg::*;
#(
  parameter int unsigned N_PERIPH = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic [N_PERIPH-1:0] clk_en_o
);
  logic [N_PERIPH-1:0][DIV_W-1:0] div_w;
  logic [N_PERIPH-1:0]            en_w;

  pclk_cfg_bank #(.N_PERIPH(N_PERIPH)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o),
    .div_o    (div_w),
    .en_o     (en_w)
  );

  for (genvar g = 0; g < N_PERIPH; g++) begin : g_pulse
    pclk_pulse_gen u_gen (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_w[g]),
      .div_i  (div_w[g]),
      .pulse_o(clk_en_o[g])
    );
  end

  // R7: disabled peripheral never pulses
  a_r7_disabled_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[CMD_BIT] && !wr_data_i[EN_BIT])
      |=> !clk_en_o[$past(wr_data_i[ID_LSB +: $clog2(N_PERIPH)])]);
endmodule

// File: tb/pclk_cfg_top_tb.sv
module pclk_cfg_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;
  logic [N-1:0]  clk_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [1:0] m_div [N];
  logic [1:0] m_act [N];
  logic       m_en  [N];
  logic [5:0] m_sel;
  logic [2:0] ph;

  always #(CLK_PERIOD/2) clk = ~clk;

  pclk_cfg_top #(.N_PERIPH(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .clk_en_o(clk_en)
  );

  function automatic logic [2:0] mask_of(input logic [1:0] d);
    return 3'((1 << d) - 1);
  endfunction

  function automatic logic [31:0] mk(input logic [5:0] id, input bit cmd,
                                     input logic [1:0] d, input bit en, input logic [31:0] junk);
    logic [31:0] w;
    w = junk & ~32'h1003_103F;
    w[5:0] = id; w[12] = cmd; w[17:16] = d; w[28] = en;
    return w;
  endfunction

  function automatic logic [31:0] exp_rd();
    logic [31:0] w;
    w = '0;
    w[5:0] = m_sel; w[17:16] = m_div[m_sel]; w[28] = m_en[m_sel];
    return w;
  endfunction

  // reference model, updated from bench-side stimulus
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= '0; m_sel <= '0;
      for (int p = 0; p < N; p++) begin m_div[p] <= '0; m_act[p] <= '0; m_en[p] <= 1'b0; end
    end else begin
      ph <= ph + 3'd1;
      if (ph == 3'd7) for (int p = 0; p < N; p++) m_act[p] <= m_div[p];
      if (wr_en) begin
        m_sel <= wr_data[5:0];
        if (wr_data[12]) begin
          m_div[wr_data[5:0]] <= wr_data[17:16];
          m_en[wr_data[5:0]]  <= wr_data[28];
        end
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // R8 R9: every cycle, all 64 pulse streams against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [N-1:0] e;
      for (int p = 0; p < N; p++) e[p] = m_en[p] && ((ph & mask_of(m_act[p])) == 3'd0);
      chk("R8/R9 pulse pattern", 64'(clk_en), 64'(e));
    end
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = $urandom;
  endtask

  task automatic rd_chk(input string req);
    chk(req, 64'(rd_data), 64'(exp_rd()));
  endtask

  task automatic rate_chk(input string req, input int p);
    int c;
    c = 0;
    repeat (16) @(negedge clk);
    repeat (64) begin @(negedge clk); if (clk_en[p]) c++; end
    chk(req, 64'(c), 64'(m_en[p] ? (64 >> m_div[p]) : 0));
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 read word", 64'(rd_data), 64'h0);
    chk("R1 pulses", 64'(clk_en), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", 64'(clk_en), 64'h0);

    // R2: selector-only write with settings fields filled
    wr(mk(6'd5, 1'b0, 2'd3, 1'b1, 32'hFFFF_FFFF));
    rd_chk("R2 select only");
    chk("R2 no enable", 64'(rd_data[28]), 64'h0);

    // R4 R3 command writes with junk bits
    wr(mk(6'd63, 1'b1, 2'd3, 1'b1, 32'hA5A5_A5A5));
    rd_chk("R4 store id63");
    chk("R3 cmd bit zero", 64'(rd_data[12]), 64'h0);
    wr(mk(6'd0, 1'b1, 2'd1, 1'b1, 32'h5A5A_5A5A));
    rd_chk("R4 store id0");
    wr(mk(6'd63, 1'b0, 2'd0, 1'b0, 32'h0));
    rd_chk("R6 id63 kept");

    // R7 rates
    rate_chk("R7 rate id63 div3", 63);
    rate_chk("R7 rate id0 div1", 0);
    rate_chk("R7 rate id1 off", 1);

    // R5 disable by read-modify-write
    wr(mk(6'd63, 1'b0, 2'd0, 1'b0, 32'h0));
    w = rd_data; w[28] = 1'b0; w[12] = 1'b1;
    wr(w);
    chk("R5 div kept", 64'(rd_data[17:16]), 64'd3);
    chk("R5 disabled", 64'(rd_data[28]), 64'h0);
    rate_chk("R5 id63 silent", 63);

    // R9 divider change between wraps
    wr(mk(6'd7, 1'b1, 2'd0, 1'b1, 32'h0));
    repeat (16) @(negedge clk);
    while (ph != 3'd1) @(negedge clk);
    wr(mk(6'd7, 1'b1, 2'd3, 1'b1, 32'h0));
    while (ph != 3'd5) @(negedge clk);
    chk("R9 old code before wrap", 64'(clk_en[7]), 64'h1);
    @(negedge clk);
    while (ph != 3'd4) @(negedge clk);
    chk("R9 new code after wrap", 64'(clk_en[7]), 64'h0);
    rate_chk("R9 id7 div3 rate", 7);

    // random mix: R2 R3 R4 R6
    for (int i = 0; i < 300; i++) begin
      logic [5:0] id;
      id = 6'($urandom_range(0, N-1));
      wr(mk(id, 1'($urandom), 2'($urandom), 1'($urandom), $urandom));
      rd_chk("R4 random write readback");
      id = 6'($urandom_range(0, N-1));
      wr(mk(id, 1'b0, 2'($urandom), 1'($urandom), $urandom));
      rd_chk("R6 random select readback");
    end

    for (int k = 0; k < 6; k++) rate_chk("R7 random rate", int'($urandom_range(0, N-1)));

    finish_up();
  end
endmodule